// File: doc/BRIEF.md
# Symmetric Up-Down PWM Gray-Shade Generator

This block converts a set of stored gray levels into one pulse-width-modulated output per channel. All channels share one master counter. A load-count strobe arms a new cycle. The counter then descends from its top value (all ones) to 1 and climbs back to the top. It takes one step on every edge of a slow count clock, rising and falling alike.

A channel turns active when the descending counter equals its level. It turns inactive when the ascending counter equals the level again. Each pulse is therefore centred on the turnaround, and its width grows with the level.

The count clock is asynchronous to the fast system clock. It is brought in through a synchronizer, and each of its transitions becomes a one-clock step request. A blank input aborts the cycle and forces every output inactive. A polarity input selects active-high or active-low pulses. A one-clock done pulse marks the end of each cycle, after which the counter holds until the next load.

Top module: `pwm_gray_gen`

## Requirements
- R1: A load-count pulse (load_i high for one clock) sets the counter to the top value MAX = 2^W-1 and starts a cycle. A load during a running cycle restarts it from the top.
- R2: Each transition of cnt_clk_i, rising or falling, advances the cycle by exactly one step. The outputs reflect that step within 4 system clocks. The step sequence after a load is MAX (repeated once), MAX-1, ..., 2, 1, 1, 2, ..., MAX, followed by one final step that ends the cycle.
- R3: A channel with a nonzero level L turns active at the step where the descending counter equals L.
- R4: An active channel turns inactive at the step where the ascending counter equals L. The second 1 at the turnaround counts as ascending.
- R5: A channel with level 0 never turns active.
- R6: The step after the ascending counter reaches MAX ends the cycle. done_o is high for exactly one system clock, and later count-clock transitions change nothing until the next load.
- R7: Before the first load after reset, count-clock transitions do not start a cycle, and all outputs stay inactive.
- R8: blank_i high returns the counter to MAX with no cycle running, and clears every channel to inactive within one clock. Later count-clock transitions change nothing until a load.
- R9: With pol_i high an active channel drives 1 and an inactive channel drives 0. With pol_i low every output is inverted.
- R10: A channel with level MAX turns active as soon as the cycle is loaded. It stays active until the ascending counter reaches MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_clk_i | input | 1 | Asynchronous count clock; each edge is one step |
| load_i | input | 1 | Load-count strobe, starts a cycle |
| blank_i | input | 1 | Abort cycle and force outputs inactive |
| pol_i | input | 1 | Output polarity, 1 = active high |
| levels_i | input | NCH*W | Channel levels, channel i in bits [i*W +: W] |
| pulse_o | output | NCH | Per-channel pulse outputs |
| done_o | output | 1 | One-clock pulse at the end of a cycle |

## Verification
The bench builds the block with NCH = 6 and W = 5. This shortens a cycle to 63 count steps, so many complete cycles fit in the run. It also puts level 0, level 1, level MAX-1 and level MAX side by side on one counter.

With the narrow counter, the bench can cover several more situations in reasonable time:
- both turnaround repeats (the doubled 1 and the doubled MAX);
- a restart by load in mid-cycle;
- blanking in mid-cycle under inverted polarity.

In each case every step is compared against a model that records which values the descent and the ascent have visited.

// File: rtl/gs_pkg.sv
package gs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DOWN  = 2'd2,
        PH_UP    = 2'd3
    } phase_e;

    function automatic logic is_descending(input phase_e ph);
        return (ph == PH_START) || (ph == PH_DOWN);
    endfunction

endpackage

// File: rtl/gs_edge_sync.sv
module gs_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic step_o
);
    logic [STAGES:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-1:0], async_i};
    end

    assign step_o = sr[STAGES] ^ sr[STAGES-1];

    // R2: a single transition yields a single step request
    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        (step_o && $stable(async_i) && $past($stable(async_i))) |=> !step_o);
endmodule

// File: rtl/gs_updown_ctr.sv
module gs_updown_ctr
    import gs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_i,
    input  logic         load_i,
    input  logic         blank_i,
    output logic [W-1:0] cnt_o,
    output phase_e       phase_o,
    output logic         done_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst || blank_i) begin
            cnt_o   <= TOP;
            phase_o <= PH_IDLE;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (load_i) begin
                cnt_o   <= TOP;
                phase_o <= PH_START;
            end else if (step_i) begin
                case (phase_o)
                    PH_START: phase_o <= PH_DOWN;
                    PH_DOWN: begin
                        if (cnt_o == ONE) phase_o <= PH_UP;
                        else              cnt_o   <= cnt_o - ONE;
                    end
                    PH_UP: begin
                        if (cnt_o == TOP) begin
                            phase_o <= PH_IDLE;
                            done_o  <= 1'b1;
                        end else begin
                            cnt_o <= cnt_o + ONE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: the counter never holds zero
    assert_never_zero_R1: assert property (@(posedge clk) disable iff (rst)
        cnt_o != '0);
    // R6: done lasts one clock
    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R6: idle counter holds until load
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_IDLE && !load_i && !blank_i) |=> (phase_o == PH_IDLE && $stable(cnt_o)));
    // R8: blank parks the counter at the top
    assert_blank_park_R8: assert property (@(posedge clk) disable iff (rst)
        blank_i |=> (cnt_o == TOP && phase_o == PH_IDLE));
    // R1: load arms a cycle from the top
    assert_load_arm_R1: assert property (@(posedge clk) disable iff (rst)
        (load_i && !blank_i) |=> (cnt_o == TOP && phase_o == PH_START));
endmodule

// File: rtl/gs_chan.sv
module gs_chan
    import gs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         blank_i,
    input  logic         load_i,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] cnt_i,
    input  phase_e       phase_i,
    output logic         act_o
);
    logic hit;
    assign hit = (level_i != '0) && (cnt_i == level_i);

    always_ff @(posedge clk) begin
        if (rst || blank_i || load_i) begin
            act_o <= 1'b0;
        end else if (hit) begin
            if (is_descending(phase_i))   act_o <= 1'b1;
            else if (phase_i == PH_UP)    act_o <= 1'b0;
        end
    end

    // R3 and R5: activation only on a nonzero match while descending
    assert_rise_on_match_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(act_o) |-> ($past(level_i) != '0 && $past(cnt_i) == $past(level_i)
                          && is_descending($past(phase_i))));
    // R4: deactivation only on an ascending match, blank or load
    assert_fall_on_match_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(act_o) |-> ($past(blank_i) || $past(load_i)
                          || ($past(cnt_i) == $past(level_i) && $past(phase_i) == PH_UP)));
    // R8: blank clears the channel
    assert_blank_clear_R8: assert property (@(posedge clk) disable iff (rst)
        blank_i |=> !act_o);
endmodule

// File: rtl/pwm_gray_gen.sv
module pwm_gray_gen
    import gs_pkg::*;
#(
    parameter int NCH         = 32,
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_clk_i,
    input  logic             load_i,
    input  logic             blank_i,
    input  logic             pol_i,
    input  logic [NCH*W-1:0] levels_i,
    output logic [NCH-1:0]   pulse_o,
    output logic             done_o
);
    logic         step;
    logic [W-1:0] cnt;
    phase_e       phase;
    logic [NCH-1:0] act;

    gs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_i(cnt_clk_i), .step_o(step)
    );

    gs_updown_ctr #(.W(W)) u_ctr (
        .clk(clk), .rst(rst), .step_i(step), .load_i(load_i), .blank_i(blank_i),
        .cnt_o(cnt), .phase_o(phase), .done_o(done_o)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        gs_chan #(.W(W)) u_ch (
            .clk(clk), .rst(rst), .blank_i(blank_i), .load_i(load_i),
            .level_i(levels_i[i*W +: W]), .cnt_i(cnt), .phase_i(phase),
            .act_o(act[i])
        );
        // R9: output follows channel state under the chosen polarity
        assign pulse_o[i] = pol_i ? act[i] : ~act[i];
    end

    // R6: done only follows an ascending phase
    assert_done_after_up_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(phase) == PH_UP && phase == PH_IDLE));
endmodule

// File: tb/sim_pwm_gray_gen.sv
module sim_pwm_gray_gen;
    localparam int NCH = 6;
    localparam int W   = 5;
    localparam int MAX = (1 << W) - 1;

    logic clk = 0, rst = 1, cnt_clk = 0, load = 0, blank = 0, pol = 1;
    logic [NCH*W-1:0] levels;
    logic [NCH-1:0]   pulse;
    logic             done;

    int lvl [NCH];
    int checks = 0, fails = 0;
    int done_total = 0, done_dbl = 0, exp_done = 0;
    logic prev_done = 0;

    // model state
    int mcnt = MAX, mmode = 0;  // 0 idle, 1 start, 2 down, 3 up
    bit dseen [0:MAX];
    bit useen [0:MAX];

    always #4 clk = ~clk;

    pwm_gray_gen #(.NCH(NCH), .W(W)) u0 (
        .clk(clk), .rst(rst), .cnt_clk_i(cnt_clk), .load_i(load), .blank_i(blank),
        .pol_i(pol), .levels_i(levels), .pulse_o(pulse), .done_o(done)
    );

    always_comb begin
        for (int i = 0; i < NCH; i++) levels[i*W +: W] = W'(lvl[i]);
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (done) done_total++;
            if (done && prev_done) done_dbl++;
            prev_done <= done;
        end
    end

    task automatic clear_seen();
        for (int v = 0; v <= MAX; v++) begin dseen[v] = 0; useen[v] = 0; end
    endtask

    task automatic model_step();
        case (mmode)
            1: mmode = 2;
            2: if (mcnt == 1) begin mmode = 3; useen[1] = 1; end
               else begin mcnt--; dseen[mcnt] = 1; end
            3: if (mcnt == MAX) begin mmode = 0; exp_done++; end
               else begin mcnt++; useen[mcnt] = 1; end
            default: ;
        endcase
    endtask

    task automatic check_out(input string tag);
        logic [NCH-1:0] exp;
        bit bad = 0;
        for (int i = 0; i < NCH; i++) begin
            bit a;
            a = (lvl[i] != 0) && dseen[lvl[i]] && !useen[lvl[i]];
            exp[i] = pol ? a : !a;
        end
        checks++;
        if (pulse !== exp) begin
            bad = 1;
            for (int i = 0; i < NCH; i++)
                if (pulse[i] !== exp[i])
                    $display("FAIL %s ch%0d level %0d: actual %b expected %b",
                             (lvl[i] == 0) ? "R5" : (lvl[i] == MAX) ? "R10" : tag,
                             i, lvl[i], pulse[i], exp[i]);
        end
        if (done_total != exp_done || done_dbl != 0) begin
            bad = 1;
            $display("FAIL R6 done pulses: actual %0d (double %0d) expected %0d",
                     done_total, done_dbl, exp_done);
        end
        if (bad) fails++;
    endtask

    task automatic edge_step(input string tag);
        @(negedge clk) cnt_clk = ~cnt_clk;
        model_step();
        repeat (6) @(negedge clk);
        check_out(tag);
    endtask

    task automatic do_load(input string tag);
        @(negedge clk) load = 1;
        @(negedge clk) load = 0;
        clear_seen();
        mcnt = MAX; mmode = 1; dseen[MAX] = 1;
        repeat (4) @(negedge clk);
        check_out(tag);
    endtask

    task automatic do_blank(input string tag);
        @(negedge clk) blank = 1;
        @(negedge clk) blank = 0;
        clear_seen();
        mcnt = MAX; mmode = 0;
        repeat (2) @(negedge clk);
        check_out(tag);
    endtask

    task automatic run_cycle(input string tag);
        for (int g = 0; g < 200 && mmode != 0; g++) edge_step(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        lvl = '{0, 1, 2, 15, 30, 31};
        clear_seen();
        repeat (3) @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);
        check_out("R7");                          // reset state
        for (int k = 0; k < 4; k++) edge_step("R7"); // no load: no cycle

        do_load("R1");                             // R10: level MAX active at load
        run_cycle("R2 R3 R4");                     // full cycle, normal polarity
        for (int k = 0; k < 3; k++) edge_step("R6"); // hold after done

        pol = 0;                                   // R9 inverted polarity
        lvl = '{31, 7, 0, 20, 1, 3};
        @(negedge clk) check_out("R9");
        do_load("R9");
        run_cycle("R9 R3 R4");

        do_load("R1");                             // blank mid-cycle
        for (int k = 0; k < 12; k++) edge_step("R3");
        do_blank("R8");
        for (int k = 0; k < 4; k++) edge_step("R8");

        pol = 1;
        lvl = '{2, 31, 16, 0, 29, 1};
        do_load("R1");
        for (int k = 0; k < 40; k++) edge_step("R4");
        do_load("R1");                             // restart mid-cycle
        run_cycle("R2 R10");
        for (int k = 0; k < 2; k++) edge_step("R6");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule